// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path and decides whether an incoming frame is kept, using only its 48-bit destination address. The address bytes are presented one per valid cycle, with a start strobe marking the first byte. While the bytes arrive, the block folds each one into a running CRC-32. It also collects the address so that the address can be compared with a station address and a small table of exact-match unicast entries.

Multicast destinations are filtered through a bin table. The complemented CRC is bit-reversed, and its top 6, 7 or 8 bits select one bin in a table of 64, 128 or 256 bits. The table is loaded as 32-bit words. Three override controls take precedence over the table: accept everything, accept every multicast, and accept multicast only through the table. One cycle after the sixth address byte, the block gives a single-cycle decision pulse together with an accept flag.

Top module: `rx_da_filter`

## Requirements
- R1: While reset is asserted and afterwards, decision_valid stays low until a full six-byte address has been taken, and decision_accept is low out of reset.
- R2: A byte is taken when da_valid is high. da_start together with da_valid marks byte 0 and restarts collection, discarding any partial address. In the cycle after the clock edge that takes byte 5, decision_valid is high for exactly one cycle. Bytes that arrive after byte 5 without a new start are ignored.
- R3: The hash is the CRC-32 of the six address bytes, taken in arrival order, with each byte processed LSB first. The CRC uses the reflected polynomial 0xEDB88320, a preset of all ones and a complemented result. The bin index is the top N bits of the complemented CRC after bit reversal, where N = cfg_bins_log2.
- R4: Bin index bits [N-1:5] select table word hash_wr_idx, and bits [4:0] select the bit within that word. With N = 6 only words 0 (low) and 1 (high) are used, with N = 7 words 0 to 3, and with N = 8 words 0 to 7.
- R5: When cfg_promisc is high, every address is accepted.
- R6: The all-ones broadcast address is always accepted.
- R7: When cfg_pass_mcast is high, every multicast address is accepted whatever the table holds. An address is multicast when bit 0 of its first byte is 1.
- R8: When cfg_hash_mcast is high and the pass and promiscuous controls are low, a multicast address is accepted only if its table bit is 1.
- R9: A non-broadcast multicast address is rejected when the promiscuous, pass and hash controls are all low.
- R10: A cfg_bins_log2 value outside 6..8 causes every non-broadcast multicast address to be rejected, unless cfg_pass_mcast or cfg_promisc is high.
- R11: A unicast address is accepted when it equals station_addr, or equals entry i (i = 1..UC_ENTRIES) held in uc_addr bits [48i-1:48(i-1)] while uc_enable[i-1] is 1. Byte k of the address (k = 0 first received) sits in bits [8k+7:8k].
- R12: A unicast address that matches only a disabled entry, or no entry at all, is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Address byte valid |
| da_start | input | 1 | Marks byte 0 of an address |
| da_byte | input | 8 | Address byte |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_pass_mcast | input | 1 | Accept all multicast frames |
| cfg_hash_mcast | input | 1 | Filter multicast through the bin table |
| cfg_bins_log2 | input | 4 | Number of index bits N (6, 7 or 8) |
| hash_wr_en | input | 1 | Write one table word |
| hash_wr_idx | input | MAX_BINS_LOG2-5 | Table word index |
| hash_wr_data | input | 32 | Table word data |
| station_addr | input | 48 | Station unicast address |
| uc_addr | input | 48*UC_ENTRIES | Exact-match entries 1..UC_ENTRIES |
| uc_enable | input | UC_ENTRIES | Per-entry enable |
| decision_valid | output | 1 | One-cycle decision pulse |
| decision_accept | output | 1 | Accept flag, valid with decision_valid |

## Verification
The bench uses the default parameters: four exact-match entries and a maximum of 8 index bits, so the table is eight words. This lets one build exercise all three supported bin counts and the out-of-range settings on either side of them, simply by changing cfg_bins_log2. For each bin count, the bench computes the expected bin bit-serially for several multicast addresses. It then proves the mapping twice: once with a table that holds only the expected bin, and once with a table that holds every bin except that one. With four entries, both an enabled entry match and a disabled entry that must not match fit in the same setup.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int          ADDR_BYTES    = 6;
    localparam int          ADDR_W        = ADDR_BYTES * 8;
    localparam int          CRC_W         = 32;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam int          MIN_BINS_LOG2 = 6;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rxf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] acc;

    always_comb begin
        acc = crc_in ^ {{(CRC_W-8){1'b0}}, data};
        for (int i = 0; i < 8; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ CRC_POLY_REFL) : (acc >> 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/rxf_hash_bin.sv
module rxf_hash_bin
    import rxf_pkg::*;
#(
    parameter int MAX_BINS_LOG2 = 8,
    localparam int TBL_BITS     = 1 << MAX_BINS_LOG2
) (
    input  logic [CRC_W-1:0]    crc_raw,
    input  logic [3:0]          bins_log2,
    input  logic [TBL_BITS-1:0] table_bits,
    output logic                bins_ok,
    output logic                bin_hit
);
    logic [CRC_W-1:0]         fin;
    logic [CRC_W-1:0]         rev;
    logic [MAX_BINS_LOG2-1:0] idx_full;
    logic [MAX_BINS_LOG2-1:0] idx;
    logic [3:0]               shamt;

    always_comb begin
        fin = ~crc_raw;
        for (int i = 0; i < CRC_W; i++) begin
            rev[CRC_W-1-i] = fin[i];
        end
        idx_full = rev[CRC_W-1 -: MAX_BINS_LOG2];
        bins_ok  = (bins_log2 >= 4'(MIN_BINS_LOG2)) && (bins_log2 <= 4'(MAX_BINS_LOG2));
        shamt    = bins_ok ? (4'(MAX_BINS_LOG2) - bins_log2) : 4'd0;
        idx      = idx_full >> shamt;
        // word = idx[N-1:5], bit = idx[4:0]: the flat table position is idx itself
        bin_hit  = bins_ok && table_bits[idx];
    end
endmodule

// File: rtl/rxf_uc_match.sv
module rxf_uc_match
    import rxf_pkg::*;
#(
    parameter int UC_ENTRIES = 4
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [ADDR_W-1:0]            station,
    input  logic [ADDR_W*UC_ENTRIES-1:0] entries,
    input  logic [UC_ENTRIES-1:0]        enables,
    output logic                         hit
);
    logic [UC_ENTRIES-1:0] ent_hit;

    for (genvar g = 0; g < UC_ENTRIES; g++) begin : g_ent
        assign ent_hit[g] = enables[g] && (addr == entries[g*ADDR_W +: ADDR_W]);
    end

    assign hit = (addr == station) || (|ent_hit);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rxf_pkg::*;
#(
    parameter int UC_ENTRIES    = 4,
    parameter int MAX_BINS_LOG2 = 8,
    localparam int TBL_BITS     = 1 << MAX_BINS_LOG2,
    localparam int WIDX_W       = MAX_BINS_LOG2 - 5,
    localparam int CNT_W        = $clog2(ADDR_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         da_valid,
    input  logic                         da_start,
    input  logic [7:0]                   da_byte,
    input  logic                         cfg_promisc,
    input  logic                         cfg_pass_mcast,
    input  logic                         cfg_hash_mcast,
    input  logic [3:0]                   cfg_bins_log2,
    input  logic                         hash_wr_en,
    input  logic [WIDX_W-1:0]            hash_wr_idx,
    input  logic [31:0]                  hash_wr_data,
    input  logic [ADDR_W-1:0]            station_addr,
    input  logic [ADDR_W*UC_ENTRIES-1:0] uc_addr,
    input  logic [UC_ENTRIES-1:0]        uc_enable,
    output logic                         decision_valid,
    output logic                         decision_accept
);
    typedef struct packed {
        logic                busy;
        logic [CNT_W-1:0]    cnt;
        logic [CRC_W-1:0]    crc;
        logic [ADDR_W-1:0]   addr;
        logic [TBL_BITS-1:0] tbl;
        logic                done;
        logic                accept;
    } state_t;

    state_t st_d, st_q;

    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [CNT_W-1:0]  pos;
    logic              take;
    logic              last;
    logic              bins_ok;
    logic              bin_hit;
    logic              uc_hit;
    logic              is_mcast;
    logic              is_bcast;
    logic              accept_c;

    assign crc_seed = (da_valid && da_start) ? '1 : st_q.crc;

    rxf_crc_byte u_crc (
        .crc_in  (crc_seed),
        .data    (da_byte),
        .crc_out (crc_nx)
    );

    rxf_hash_bin #(.MAX_BINS_LOG2(MAX_BINS_LOG2)) u_bin (
        .crc_raw    (crc_nx),
        .bins_log2  (cfg_bins_log2),
        .table_bits (st_q.tbl),
        .bins_ok    (bins_ok),
        .bin_hit    (bin_hit)
    );

    rxf_uc_match #(.UC_ENTRIES(UC_ENTRIES)) u_uc (
        .addr    (addr_nx),
        .station (station_addr),
        .entries (uc_addr),
        .enables (uc_enable),
        .hit     (uc_hit)
    );

    always_comb begin
        pos     = da_start ? '0 : st_q.cnt;
        take    = da_valid && (da_start || st_q.busy);
        last    = take && (pos == CNT_W'(ADDR_BYTES - 1));
        addr_nx = st_q.addr;
        addr_nx[pos*8 +: 8] = da_byte;

        is_mcast = addr_nx[0];
        is_bcast = &addr_nx;
        if (cfg_promisc || is_bcast) begin
            accept_c = 1'b1;
        end else if (is_mcast) begin
            accept_c = cfg_pass_mcast || (cfg_hash_mcast && bins_ok && bin_hit);
        end else begin
            accept_c = uc_hit;
        end

        st_d      = st_q;
        st_d.done = 1'b0;
        if (take) begin
            st_d.crc  = crc_nx;
            st_d.addr = addr_nx;
            st_d.cnt  = pos + CNT_W'(1);
            st_d.busy = !last;
            if (last) begin
                st_d.done   = 1'b1;
                st_d.accept = accept_c;
            end
        end
        if (hash_wr_en) begin
            st_d.tbl[hash_wr_idx*32 +: 32] = hash_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.crc    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision_valid  = st_q.done;
    assign decision_accept = st_q.accept;
endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
    parameter int MAX_BINS_LOG2 = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       da_valid,
    input logic       da_start,
    input logic [7:0] da_byte,
    input logic       cfg_promisc,
    input logic       cfg_pass_mcast,
    input logic       cfg_hash_mcast,
    input logic [3:0] cfg_bins_log2,
    input logic       decision_valid,
    input logic       decision_accept
);
    logic mc_q;
    logic bc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q <= 1'b0;
            bc_q <= 1'b0;
        end else if (da_valid && da_start) begin
            mc_q <= da_byte[0];
            bc_q <= (da_byte == 8'hFF);
        end else if (da_valid) begin
            bc_q <= bc_q && (da_byte == 8'hFF);
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);

    assert_done_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(da_valid));

    assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && $past(cfg_promisc)) |-> decision_accept);

    assert_bcast_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && bc_q) |-> decision_accept);

    assert_pass_mcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && mc_q && $past(cfg_pass_mcast)) |-> decision_accept);

    assert_mcast_off_rejects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && mc_q && !bc_q && !$past(cfg_promisc) && !$past(cfg_pass_mcast)
         && !$past(cfg_hash_mcast)) |-> !decision_accept);

    assert_bad_bins_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && mc_q && !bc_q && !$past(cfg_promisc) && !$past(cfg_pass_mcast)
         && (($past(cfg_bins_log2) < 4'd6) || ($past(cfg_bins_log2) > 4'(MAX_BINS_LOG2))))
        |-> !decision_accept);
endmodule

bind rx_da_filter rxf_checks #(.MAX_BINS_LOG2(MAX_BINS_LOG2)) u_rxf_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .da_valid        (da_valid),
    .da_start        (da_start),
    .da_byte         (da_byte),
    .cfg_promisc     (cfg_promisc),
    .cfg_pass_mcast  (cfg_pass_mcast),
    .cfg_hash_mcast  (cfg_hash_mcast),
    .cfg_bins_log2   (cfg_bins_log2),
    .decision_valid  (decision_valid),
    .decision_accept (decision_accept)
);

// File: tb/tb_rx_da_filter.sv
`timescale 1ns/1ps
module tb_rx_da_filter;
    localparam int UCN = 4;
    localparam int MAXB = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           da_valid = 1'b0;
    logic           da_start = 1'b0;
    logic [7:0]     da_byte = 8'h00;
    logic           cfg_promisc = 1'b0;
    logic           cfg_pass_mcast = 1'b0;
    logic           cfg_hash_mcast = 1'b0;
    logic [3:0]     cfg_bins_log2 = 4'd6;
    logic           hash_wr_en = 1'b0;
    logic [2:0]     hash_wr_idx = 3'd0;
    logic [31:0]    hash_wr_data = 32'h0;
    logic [47:0]    station_addr = 48'h0;
    logic [48*UCN-1:0] uc_addr = '0;
    logic [UCN-1:0] uc_enable = '0;
    logic           decision_valid;
    logic           decision_accept;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_da_filter #(.UC_ENTRIES(UCN), .MAX_BINS_LOG2(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_start(da_start),
        .da_byte(da_byte), .cfg_promisc(cfg_promisc), .cfg_pass_mcast(cfg_pass_mcast),
        .cfg_hash_mcast(cfg_hash_mcast), .cfg_bins_log2(cfg_bins_log2),
        .hash_wr_en(hash_wr_en), .hash_wr_idx(hash_wr_idx), .hash_wr_data(hash_wr_data),
        .station_addr(station_addr), .uc_addr(uc_addr), .uc_enable(uc_enable),
        .decision_valid(decision_valid), .decision_accept(decision_accept)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // bit-serial reference of the bin index (R3)
    function automatic int ref_bin(input logic [47:0] a, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] x;
        int idx = 0;
        for (int k = 0; k < 48; k++) begin
            logic fb = c[0] ^ a[k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        x = ~c;
        for (int j = 0; j < n; j++) idx = (idx << 1) | int'(x[j]);
        return idx;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load_table(input logic [255:0] t);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            hash_wr_en = 1'b1; hash_wr_idx = 3'(w); hash_wr_data = t[w*32 +: 32];
        end
        @(negedge clk);
        hash_wr_en = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, output logic dv, output logic acc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_start = (i == 0); da_byte = a[i*8 +: 8];
        end
        @(negedge clk);
        da_valid = 1'b0; da_start = 1'b0;
        dv = decision_valid; acc = decision_accept;
        @(negedge clk);
        if (decision_valid !== 1'b0) begin
            checks++; errors++;
            $display("FAIL R2: pulse longer than one cycle actual=1 expected=0");
        end
    endtask

    task automatic expect_dec(input string req, input logic [47:0] a, input logic exp);
        logic dv, acc;
        send(a, dv, acc);
        chk({req, " valid"}, dv, 1'b1);
        chk(req, acc, exp);
    endtask

    task automatic cfg(input logic p, input logic pm, input logic hm, input logic [3:0] nb);
        cfg_promisc = p; cfg_pass_mcast = pm; cfg_hash_mcast = hm; cfg_bins_log2 = nb;
    endtask

    localparam logic [47:0] STA = 48'h5544_3322_1100;
    localparam logic [47:0] E1  = 48'h0605_0403_0200;
    localparam logic [47:0] E2  = 48'hAA99_8877_6602;
    localparam logic [47:0] E3  = 48'hCCBB_0000_EE04;

    task automatic t_reset;
        chk("R1 valid in reset", decision_valid, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 valid idle", decision_valid, 1'b0);
        end
        chk("R1 accept idle", decision_accept, 1'b0);
    endtask

    task automatic t_unicast;
        cfg(0, 0, 0, 4'd6);
        expect_dec("R11 station", STA, 1'b1);
        expect_dec("R11 entry1", E1, 1'b1);
        expect_dec("R11 entry2", E2, 1'b1);
        expect_dec("R12 disabled entry3", E3, 1'b0);
        expect_dec("R12 no match", 48'h1234_5678_9A10, 1'b0);
    endtask

    task automatic t_promisc;
        cfg(1, 0, 0, 4'd6);
        expect_dec("R5 unicast", 48'h1234_5678_9A10, 1'b1);
        expect_dec("R5 multicast", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h09), 1'b1);
    endtask

    task automatic t_bcast_pass;
        load_table('0);
        cfg(0, 0, 0, 4'd6);
        expect_dec("R6 bcast all off", 48'hFFFF_FFFF_FFFF, 1'b1);
        cfg(0, 0, 1, 4'd3);
        expect_dec("R6 bcast bad bins", 48'hFFFF_FFFF_FFFF, 1'b1);
        cfg(0, 0, 0, 4'd6);
        expect_dec("R9 mcast all off", mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 1'b0);
        cfg(0, 1, 0, 4'd6);
        expect_dec("R7 pass mcast", mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 1'b1);
        cfg(0, 1, 1, 4'd6);
        expect_dec("R7 pass over empty table", mk(8'h0B, 8'hAD, 8'hCA, 8'hFE, 8'h12, 8'h34), 1'b1);
        expect_dec("R7 unicast still exact", 48'h1234_5678_9A10, 1'b0);
    endtask

    task automatic t_hash;
        logic [47:0] addrs [4];
        addrs[0] = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
        addrs[1] = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01);
        addrs[2] = mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h00);
        addrs[3] = mk(8'h0B, 8'hAD, 8'hCA, 8'hFE, 8'h12, 8'h34);
        for (int n = 6; n <= 8; n++) begin
            cfg(0, 0, 1, 4'(n));
            for (int a = 0; a < 4; a++) begin
                logic [255:0] t = '0;
                int b = ref_bin(addrs[a], n);
                t[b] = 1'b1;
                load_table(t);
                expect_dec("R3 R4 R8 only own bin", addrs[a], 1'b1);
                load_table(~t);
                expect_dec("R3 R4 R8 all but own bin", addrs[a], 1'b0);
            end
        end
    endtask

    task automatic t_badbins;
        load_table('1);
        cfg(0, 0, 1, 4'd5);
        expect_dec("R10 bins 5", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b0);
        cfg(0, 0, 1, 4'd9);
        expect_dec("R10 bins 9", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b0);
        cfg(0, 1, 1, 4'd9);
        expect_dec("R10 bins 9 with pass", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b1);
        cfg(1, 0, 1, 4'd0);
        expect_dec("R10 bins 0 with promisc", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b1);
    endtask

    task automatic t_sequence;
        logic seen = 1'b0;
        cfg(0, 0, 0, 4'd6);
        // partial frame of a non-matching address, then restart with the station
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_start = (i == 0); da_byte = 8'hA0 + 8'(i);
            if (decision_valid) seen = 1'b1;
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_start = (i == 0); da_byte = STA[i*8 +: 8];
            if (decision_valid) seen = 1'b1;
        end
        @(negedge clk);
        da_byte = STA[47:40]; da_start = 1'b0;
        if (decision_valid) seen = 1'b1;
        chk("R2 no early pulse", seen, 1'b0);
        @(negedge clk);
        chk("R2 restart pulse", decision_valid, 1'b1);
        chk("R2 restart accept", decision_accept, 1'b1);
        // extra bytes without start
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            da_valid = 1'b1; da_start = 1'b0; da_byte = 8'h5A;
            @(negedge clk);
            if (decision_valid) seen = 1'b1;
        end
        da_valid = 1'b0;
        @(negedge clk);
        if (decision_valid) seen = 1'b1;
        chk("R2 trailing bytes ignored", seen, 1'b0);
    endtask

    initial begin
        station_addr = STA;
        uc_addr[0*48 +: 48] = E1;
        uc_addr[1*48 +: 48] = E2;
        uc_addr[2*48 +: 48] = E3;
        uc_enable = 4'b0011;
        repeat (3) @(negedge clk);
        t_reset();
        t_unicast();
        t_promisc();
        t_bcast_pass();
        t_hash();
        t_badbins();
        t_sequence();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule